// File: doc/BRIEF.md
# Low-Power Compare Timer

A 32-bit timer peripheral behind a simple word-wide register port. The count advances on rising edges of one of several slow clock inputs, selected by a field in the prescale register. Each edge is either used directly or divided by a power of two. Every slow input is treated as asynchronous to the bus clock: the selected input passes through a synchroniser, and its rising edges become single-cycle ticks in the bus domain. The counter, the compare logic and the snapshot register all run on the bus clock and advance only on those ticks.

Firmware arms the timer by writing a compare value and setting the enable bit. In compare-clear mode the count returns to zero on the tick after it reaches the compare value. In free-running mode it continues and wraps only at overflow. A match sets a sticky flag, which drives the interrupt output through an enable bit. A level trigger output is high while the running count equals the compare value. The live count cannot be read directly. A write to the counter offset copies the count into a snapshot, and reads at that offset return the snapshot. Clearing the enable bit returns the count, the flag, the prescaler and the enable synchroniser to zero.

Top module: `lp_cmp_timer`

## Requirements
- R1: After reset every register reads 0 and irq_o and trig_o are low. Byte offsets: control/status 0x0, prescale 0x4, compare 0x8, counter 0xC. Control bits: enable [0], mode [1], free-run [2], interrupt-enable [6], flag [7]. Prescale fields: source select [1:0], bypass [4], divide exponent [11:8]. Written fields read back unchanged.
- R2: Only rising edges on src_clk_i[sel] advance the timer, where sel is the source select field. Edges on the other inputs have no effect. Code 2 is the real-time clock input.
- R3: With bypass set, every rising edge of the selected source is one prescaler tick.
- R4: With bypass clear and divide exponent N, one tick occurs every 2^(N+1) source edges.
- R5: Enable synchronisation uses up the first two ticks after the enable bit is set. After T ticks the count is T-2 (for T >= 2).
- R6: With free-run 0, a tick that finds the count equal to the compare value loads 0 into the count.
- R7: With free-run 1, the count continues past the compare value and wraps to 0 only on overflow.
- R8: While enabled, a count equal to the compare value sets the flag. Writing 1 to bit 7 of control/status clears the flag unless the match is still present. irq_o equals the flag AND interrupt-enable.
- R9: trig_o is high while the timer is running and the count equals the compare value. With compare 0 in compare-clear mode, it stays high until the timer is disabled.
- R10: A write to the compare register is ignored while the timer is enabled and the flag is clear. In every other case the write is accepted.
- R11: Clearing the enable bit sets the count to 0, clears the flag and takes trig_o and irq_o low.
- R12: Writing any value to offset 0xC copies the count into the snapshot. Reads at 0xC return the snapshot, which holds its value until the next such write.
- R13: With mode 1, the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | 4 | Slow clock sources, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt (flag AND interrupt-enable) |
| trig_o | output | 1 | Hardware trigger level |

## Verification
If the enable-synchroniser or prescaler state is wrong, the snapshot value after a known number of source edges is off by a whole count. This shows at the next counter write and read, a few bus cycles after the last edge. If the compare or flag state is wrong, irq_o, trig_o or the flag bit read from control/status differ within one tick of the match. If the clear on disable is wrong, a nonzero snapshot or a flag that stays set shows at the first read after the enable bit is cleared. Edges are driven only on unselected inputs and compare writes are made while locked, and the bench then reads the count or the compare register to show that nothing changed.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_PRESC = 4'h4;
  localparam logic [3:0] OFS_CMP   = 4'h8;
  localparam logic [3:0] OFS_CNT   = 4'hC;
  localparam int B_EN   = 0;
  localparam int B_MODE = 1;
  localparam int B_FREE = 2;
  localparam int B_IE   = 6;
  localparam int B_FLAG = 7;
  localparam int P_BYP  = 4;
  localparam int P_DIV  = 8;
endpackage

// File: rtl/lpt_tick_gen.sv
module lpt_tick_gen #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2,
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             byp_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = 1 << DIV_W;

  logic [2:0]       sync_q;
  logic             edge_w;
  logic [PRE_W-1:0] pre_q, lim_w;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], src_i[sel_i]};

  assign edge_w = sync_q[1] & ~sync_q[2];
  assign lim_w  = {PRE_W{1'b1}} >> (PRE_W - 1 - int'(div_i));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || byp_i)   pre_q <= '0;
    else if (edge_w)            pre_q <= (pre_q == lim_w) ? '0 : pre_q + 1'b1;

  assign tick_o = run_i && edge_w && (byp_i || pre_q == lim_w);

  // R4: prescaler never passes its limit
  a_r4_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(div_i) |=> pre_q <= lim_w);
endmodule

// File: rtl/lpt_core.sv
module lpt_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             free_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_flag_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             trig_o
);
  logic [1:0]       en_sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, run_w, hit_w;

  // enable crosses into the tick domain through two tick-clocked stages
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     en_sync_q <= '0;
    else if (!en_i)  en_sync_q <= '0;
    else if (tick_i) en_sync_q <= {en_sync_q[0], 1'b1};

  assign run_w = en_sync_q[1] & ~mode_i;
  assign hit_w = en_sync_q[1] && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (tick_i && run_w) cnt_q <= (!free_i && cnt_q == cmp_i) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         flag_q <= 1'b0;
    else if (!en_i)      flag_q <= 1'b0;
    else if (hit_w)      flag_q <= 1'b1;
    else if (clr_flag_i) flag_q <= 1'b0;

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign trig_o = hit_w;

  a_r11_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && !flag_q);
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && run_w |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));
  a_r13_mode_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i |=> $stable(cnt_q));
  a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && trig_o |=> flag_q);
endmodule

// File: rtl/lp_cmp_timer.sv
module lp_cmp_timer
  import lpt_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int DIV_W = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_clk_i,
  input  logic             wr_en_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o,
  output logic             trig_o
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             en_q, mode_q, free_q, ie_q, byp_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cmp_q, snap_q, cnt_w;
  logic             flag_w, tick_w, clr_flag_w;
  logic             wr_ctrl, wr_presc, wr_cmp, wr_cnt;

  assign wr_ctrl  = wr_en_i && addr_i == OFS_CTRL;
  assign wr_presc = wr_en_i && addr_i == OFS_PRESC;
  assign wr_cmp   = wr_en_i && addr_i == OFS_CMP;
  assign wr_cnt   = wr_en_i && addr_i == OFS_CNT;
  assign clr_flag_w = wr_ctrl && wdata_i[B_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      {en_q, mode_q, free_q, ie_q} <= '0;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[B_EN];
      mode_q <= wdata_i[B_MODE];
      free_q <= wdata_i[B_FREE];
      ie_q   <= wdata_i[B_IE];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sel_q <= '0; byp_q <= 1'b0; div_q <= '0;
    end else if (wr_presc) begin
      sel_q <= wdata_i[SEL_W-1:0];
      byp_q <= wdata_i[P_BYP];
      div_q <= wdata_i[P_DIV +: DIV_W];
    end

  // compare is locked while running until the flag is up
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        cmp_q <= '0;
    else if (wr_cmp && (!en_q || flag_w)) cmp_q <= wdata_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     snap_q <= '0;
    else if (wr_cnt) snap_q <= cnt_w;

  lpt_tick_gen #(.N_SRC(N_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(en_q), .src_i(src_clk_i), .sel_i(sel_q),
    .byp_i(byp_q), .div_i(div_q), .tick_o(tick_w)
  );

  lpt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .en_i(en_q), .mode_i(mode_q), .free_i(free_q),
    .tick_i(tick_w), .cmp_i(cmp_q), .clr_flag_i(clr_flag_w),
    .cnt_o(cnt_w), .flag_o(flag_w), .trig_o(trig_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[B_EN] = en_q; rdata_o[B_MODE] = mode_q; rdata_o[B_FREE] = free_q;
        rdata_o[B_IE] = ie_q; rdata_o[B_FLAG] = flag_w;
      end
      OFS_PRESC: begin
        rdata_o[SEL_W-1:0] = sel_q; rdata_o[P_BYP] = byp_q;
        rdata_o[P_DIV +: DIV_W] = div_q;
      end
      OFS_CMP: rdata_o = 32'(cmp_q);
      OFS_CNT: rdata_o = 32'(snap_q);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag_w & ie_q;

  a_r10_cmp_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp && en_q && !flag_w |=> $stable(cmp_q));
  a_r12_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> $stable(snap_q));
endmodule

// File: tb/tb_lp_cmp_timer.sv
`timescale 1ns/1ps
module tb_lp_cmp_timer;
  logic        clk = 0, rst_ni = 0;
  logic [3:0]  src_clk_i = '0, addr_i = '0;
  logic        wr_en_i = 0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o, trig_o;

  lp_cmp_timer dut (.clk_i(clk), .rst_ni, .src_clk_i, .wr_en_i, .addr_i,
                    .wdata_i, .rdata_o, .irq_o, .trig_o);

  always #5 clk = ~clk;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit mon_go = 0, done = 0;

  // monitor: pops one expected item per request and compares
  always begin
    @(posedge clk);
    if (mon_go) begin
      item_t it;
      logic [31:0] act;
      #2;
      it = exp_q.pop_front();
      act = (it.kind == 0) ? rdata_o : (it.kind == 1) ? {31'b0, irq_o} : {31'b0, trig_o};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
      mon_go = 0;
    end
  end

  task automatic push(int kind, logic [3:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    addr_i = a; it.kind = kind; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    mon_go = 1;
    wait (mon_go == 0);
  endtask

  task automatic chk_rd(logic [3:0] a, logic [31:0] e, string tag); push(0, a, e, tag); endtask
  task automatic chk_irq(bit e, string tag); push(1, 4'h0, {31'b0, e}, tag); endtask
  task automatic chk_trig(bit e, string tag); push(2, 4'h0, {31'b0, e}, tag); endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic edges(int idx, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_clk_i[idx] = 1;
      repeat (4) @(negedge clk);
      src_clk_i[idx] = 0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic snap(logic [31:0] e, string tag);
    wr(4'hC, 32'hDEAD);
    chk_rd(4'hC, e, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk_rd(4'h0, 0, "R1 ctrl reset");
    chk_rd(4'h4, 0, "R1 presc reset");
    chk_rd(4'h8, 0, "R1 cmp reset");
    chk_rd(4'hC, 0, "R1 cnt reset");
    chk_irq(0, "R1 irq reset");
    chk_trig(0, "R1 trig reset");
    // select source 2, bypass
    wr(4'h4, 32'h12);
    chk_rd(4'h4, 32'h12, "R1 presc readback");
    wr(4'h8, 100);
    chk_rd(4'h8, 100, "R10 cmp write while disabled");
    wr(4'h0, 32'h5);
    chk_rd(4'h0, 32'h5, "R1 ctrl readback");
    edges(2, 5);
    snap(3, "R5 R3 five ticks give three");
    edges(1, 4);
    snap(3, "R2 unselected source ignored");
    edges(2, 1);
    snap(4, "R2 selected source counts");
    edges(2, 2);
    chk_rd(4'hC, 4, "R12 snapshot holds");
    snap(6, "R12 snapshot recapture");
    wr(4'h8, 5);
    chk_rd(4'h8, 100, "R10 cmp locked while running");
    wr(4'h0, 0);
    snap(0, "R11 disable clears count");
    chk_rd(4'h0, 0, "R11 disable clears flag");
    // compare-clear mode
    wr(4'h8, 3);
    wr(4'h0, 32'h41);
    edges(2, 5);
    snap(3, "R6 count reaches compare");
    chk_trig(1, "R9 trig on match");
    chk_irq(1, "R8 irq on match");
    chk_rd(4'h0, 32'hC1, "R8 flag set");
    edges(2, 1);
    snap(0, "R6 clear after match");
    chk_trig(0, "R9 trig drops");
    chk_irq(1, "R8 flag sticky");
    wr(4'h8, 7);
    chk_rd(4'h8, 7, "R10 cmp write with flag set");
    wr(4'h0, 32'hC1);
    chk_irq(0, "R8 flag write-one-clear");
    edges(2, 2);
    snap(2, "R6 counting resumes");
    // free run
    wr(4'h0, 0);
    wr(4'h8, 3);
    wr(4'h0, 32'h45);
    edges(2, 7);
    snap(5, "R7 free-run passes compare");
    chk_irq(1, "R7 R8 flag in free-run");
    // prescaler
    wr(4'h0, 0);
    wr(4'h4, 32'h002);
    wr(4'h0, 32'h5);
    edges(2, 10);
    snap(3, "R4 divide by 2");
    wr(4'h0, 0);
    wr(4'h4, 32'h102);
    wr(4'h0, 32'h5);
    edges(2, 12);
    snap(1, "R4 divide by 4");
    // mode bit
    wr(4'h0, 0);
    wr(4'h4, 32'h12);
    wr(4'h0, 32'h7);
    edges(2, 6);
    snap(0, "R13 mode stops counting");
    // compare zero
    wr(4'h0, 0);
    wr(4'h8, 0);
    wr(4'h0, 32'h1);
    edges(2, 3);
    chk_trig(1, "R9 cmp zero trig high");
    wr(4'h0, 32'h81);
    chk_rd(4'h0, 32'h81, "R8 clear blocked by match");
    edges(2, 4);
    chk_trig(1, "R9 cmp zero trig held");
    wr(4'h0, 0);
    chk_trig(0, "R9 R11 trig low after disable");
    chk_rd(4'h0, 0, "R11 flag cleared by disable");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule